// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Incremental Squash

This block keeps the in-flight instructions of a few hardware threads in program order. Each thread owns a circular queue. Every live slot holds a sequence number, a PC, a ready-to-commit flag and a squashed flag. The front end inserts entries tagged with a thread number. Completion marks an entry ready by naming its thread and sequence number. Commit retires the oldest entry of a chosen thread, but only once that entry is ready.

A squash for one thread walks that thread's queue from its youngest entry toward its oldest. It marks at most `SQW` entries per cycle. Each marked entry becomes squashed and ready, so it leaves later through normal in-order retirement. Freeing of physical registers is left to the surrounding logic.

The block also reports two global positions across all threads that are both active and non-empty. The global head is the thread head with the lowest sequence number. The global tail is the thread tail with the highest sequence number. Sequence numbers are unsigned, unique and increasing, and they do not wrap.

Top module: `mt_rob`

## Requirements
- R1: After reset every queue is empty: `hd_vld`, `tl_vld`, `can_commit`, all `sq_busy` bits and all `thr_full` bits are 0.
- R2: An insert appends to the tail of thread `ins_tid`. `thr_full[t]` is 1 while thread t holds `DEPTH` entries. Inserting into a full thread is not allowed.
- R3: A completion (`done_en`) sets the ready flag of the live entry of thread `done_tid` whose sequence number equals `done_seq`.
- R4: A retire request removes the oldest entry of thread `ret_tid` only when that entry is ready. Otherwise the request has no effect.
- R5: `hd_vld`/`hd_tid`/`hd_seq`/`hd_pc`/`hd_rdy`/`hd_sqd` describe the head entry with the lowest sequence number among active, non-empty threads. `hd_vld` is 0 when no such thread exists.
- R6: `tl_vld`/`tl_tid`/`tl_seq` describe the tail entry with the highest sequence number among active, non-empty threads. This includes tails that were just squashed.
- R7: `can_commit` is 1 when the head entry of any active thread is ready, even if that thread does not hold the global head.
- R8: A squash request records `sq_seq` and raises `sq_busy[sq_tid]` on the edge that samples it. The walk starts at the thread's youngest entry. If that thread is empty, including when the whole buffer is empty, the request does nothing.
- R9: On each walk cycle, at most `SQW` consecutive entries are processed, moving toward the oldest. An entry is marked only while its sequence number is greater than the recorded number, and a marked entry gets both its squashed and ready flags set.
- R10: The walk ends, and `sq_busy` clears, in the cycle it either reaches an entry at or below the recorded number or marks the thread's oldest entry.
- R11: Squashed entries stay in place and retire in order; `hd_sqd` reports the squashed flag of the global head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_act | input | NTHR | Active-thread mask for head, tail and commit selection |
| ins_en | input | 1 | Insert request |
| ins_tid | input | TW | Thread of the insert |
| ins_seq | input | SEQW | Sequence number of the inserted entry |
| ins_pc | input | PCW | PC of the inserted entry |
| done_en | input | 1 | Completion request |
| done_tid | input | TW | Thread of the completing entry |
| done_seq | input | SEQW | Sequence number of the completing entry |
| ret_en | input | 1 | Retire request |
| ret_tid | input | TW | Thread whose head is to retire |
| sq_en | input | 1 | Squash request |
| sq_tid | input | TW | Thread to squash |
| sq_seq | input | SEQW | Entries above this number are squashed |
| can_commit | output | 1 | Some active thread head is ready |
| hd_vld | output | 1 | Global head valid |
| hd_tid | output | TW | Thread of global head |
| hd_seq | output | SEQW | Sequence number of global head |
| hd_pc | output | PCW | PC of global head |
| hd_rdy | output | 1 | Global head ready flag |
| hd_sqd | output | 1 | Global head squashed flag |
| tl_vld | output | 1 | Global tail valid |
| tl_tid | output | TW | Thread of global tail |
| tl_seq | output | SEQW | Sequence number of global tail |
| sq_busy | output | NTHR | Squash walk in progress, per thread |
| thr_full | output | NTHR | Thread queue full, per thread |

## Verification
Timing is counted from the clock edge that samples a request.

- `sq_busy` and `thr_full` come straight from queue state. They are correct just after that edge.
- The head, tail and commit outputs pass through one more register. They are correct only after the following edge.
- The bench drives on the falling edge, and each operation task returns one falling edge after the sampling edge. The bench reads the flags at that point and waits one extra cycle before reading the global outputs.
- A squash walk lasts a fixed number of edges: one per `SQW`-sized group of entries above the recorded number, plus one more if the walk stops on an older entry rather than on the thread's oldest one. The bench counts how many samples `sq_busy` stays high and compares that count with the value worked out from the queue contents and `SQW`.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // width of an index able to address n items (at least one bit)
  function automatic int idw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rob_thread_q.sv
module rob_thread_q
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQW  = 16,
  parameter int PCW   = 32,
  parameter int SQW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_en,
  input  logic [SEQW-1:0] ins_seq,
  input  logic [PCW-1:0]  ins_pc,
  input  logic            done_en,
  input  logic [SEQW-1:0] done_seq,
  input  logic            ret_en,
  input  logic            sq_en,
  input  logic [SEQW-1:0] sq_seq,
  output logic            nonempty,
  output logic            full,
  output logic            head_rdy,
  output logic            head_sqd,
  output logic            busy,
  output logic [SEQW-1:0] head_seq,
  output logic [SEQW-1:0] tail_seq,
  output logic [PCW-1:0]  head_pc
);
  localparam int AW = idw(DEPTH);
  localparam int CW = AW + 1;
  localparam int OW = CW + 1;

  logic [SEQW-1:0]  seq_m [DEPTH];
  logic [PCW-1:0]   pc_m  [DEPTH];
  logic [DEPTH-1:0] vld, rdy, sqd;
  logic [AW-1:0]    hd, tl, tl_last;
  logic [CW-1:0]    cnt, walk;
  logic [SEQW-1:0]  sq_num;
  logic             busy_q;

  logic             ins_ok, ret_ok, sq_start, fin;
  logic [SQW-1:0]   mark;
  logic [AW-1:0]    mpos [SQW];

  assign tl_last  = tl - 1'b1;
  assign nonempty = (cnt != '0);
  assign full     = (cnt == CW'(DEPTH));
  assign ins_ok   = ins_en && !full;
  assign ret_ok   = ret_en && nonempty && rdy[hd];
  assign sq_start = sq_en && nonempty;

  // squash walker: up to SQW entries from the youngest side per cycle
  always_comb begin
    logic          go;
    logic [OW-1:0] off;
    go   = busy_q;
    mark = '0;
    for (int k = 0; k < SQW; k++) begin
      off     = {1'b0, walk} + OW'(k);
      mpos[k] = tl_last - off[AW-1:0];
      if (go && (off < {1'b0, cnt}) && (seq_m[mpos[k]] > sq_num))
        mark[k] = 1'b1;
      else
        go = 1'b0;
    end
    fin = busy_q && (!go || (({1'b0, walk} + OW'(SQW)) >= {1'b0, cnt}));
  end

  // payload storage: write-only on insert, no reset
  always_ff @(posedge clk) begin
    if (ins_ok) begin
      seq_m[tl] <= ins_seq;
      pc_m[tl]  <= ins_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hd     <= '0;
      tl     <= '0;
      cnt    <= '0;
      walk   <= '0;
      vld    <= '0;
      rdy    <= '0;
      sqd    <= '0;
      busy_q <= 1'b0;
      sq_num <= '0;
    end else begin
      if (done_en) begin
        for (int i = 0; i < DEPTH; i++)
          if (vld[i] && (seq_m[i] == done_seq)) rdy[i] <= 1'b1;
      end
      for (int k = 0; k < SQW; k++) begin
        if (mark[k]) begin
          rdy[mpos[k]] <= 1'b1;
          sqd[mpos[k]] <= 1'b1;
        end
      end
      if (ret_ok) begin
        vld[hd] <= 1'b0;
        hd      <= hd + 1'b1;
      end
      if (ins_ok) begin
        vld[tl] <= 1'b1;
        rdy[tl] <= 1'b0;
        sqd[tl] <= 1'b0;
        tl      <= tl + 1'b1;
      end
      cnt <= cnt + CW'(ins_ok) - CW'(ret_ok);
      if (sq_start) begin
        busy_q <= 1'b1;
        walk   <= '0;
        sq_num <= sq_seq;
      end else if (fin) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        walk <= walk + CW'(SQW);
      end
    end
  end

  assign head_rdy = nonempty && rdy[hd];
  assign head_sqd = sqd[hd];
  assign head_seq = seq_m[hd];
  assign head_pc  = pc_m[hd];
  assign tail_seq = seq_m[tl_last];
  assign busy     = busy_q;

  // R2
  ins_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    ins_en |-> !full);

  // R8
  ins_during_squash_chk: assert property (@(posedge clk) disable iff (rst)
    ins_en |-> !(busy_q || sq_en));

  // R4
  ret_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !head_rdy && !ins_en) |=> $stable(cnt) && $stable(hd));

  // R10
  sq_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (cnt == '0 || sqd[tl_last] || seq_m[tl_last] <= sq_num));
endmodule

// File: rtl/rob_pick.sv
module rob_pick
  import rob_pkg::*;
#(
  parameter int NTHR = 2,
  parameter int SEQW = 16,
  parameter int PCW  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NTHR-1:0]            act,
  input  logic [NTHR-1:0]            ne,
  input  logic [NTHR-1:0]            hrdy,
  input  logic [NTHR-1:0]            hsqd,
  input  logic [NTHR-1:0][SEQW-1:0]  hseq,
  input  logic [NTHR-1:0][SEQW-1:0]  tseq,
  input  logic [NTHR-1:0][PCW-1:0]   hpc,
  output logic                       can_commit,
  output logic                       hd_vld,
  output logic [idw(NTHR)-1:0]       hd_tid,
  output logic [SEQW-1:0]            hd_seq,
  output logic [PCW-1:0]             hd_pc,
  output logic                       hd_rdy,
  output logic                       hd_sqd,
  output logic                       tl_vld,
  output logic [idw(NTHR)-1:0]       tl_tid,
  output logic [SEQW-1:0]            tl_seq
);
  localparam int TW = idw(NTHR);

  logic            h_f, t_f;
  logic [TW-1:0]   h_t, t_t;
  logic [SEQW-1:0] h_s, t_s;
  logic [NTHR-1:0] live;

  assign live = act & ne;

  always_comb begin
    h_f = 1'b0; t_f = 1'b0;
    h_t = '0;   t_t = '0;
    h_s = '0;   t_s = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (live[t] && (!h_f || hseq[t] < h_s)) begin
        h_f = 1'b1; h_t = TW'(t); h_s = hseq[t];
      end
      if (live[t] && (!t_f || tseq[t] > t_s)) begin
        t_f = 1'b1; t_t = TW'(t); t_s = tseq[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      can_commit <= 1'b0;
      hd_vld <= 1'b0; hd_tid <= '0; hd_seq <= '0; hd_pc <= '0;
      hd_rdy <= 1'b0; hd_sqd <= 1'b0;
      tl_vld <= 1'b0; tl_tid <= '0; tl_seq <= '0;
    end else begin
      can_commit <= |(live & hrdy);
      hd_vld <= h_f;
      hd_tid <= h_t;
      hd_seq <= h_s;
      hd_pc  <= hpc[h_t];
      hd_rdy <= h_f && hrdy[h_t];
      hd_sqd <= h_f && hsqd[h_t];
      tl_vld <= t_f;
      tl_tid <= t_t;
      tl_seq <= t_s;
    end
  end

  // R6
  head_tail_order_chk: assert property (@(posedge clk) disable iff (rst)
    hd_vld |-> (tl_vld && hd_seq <= tl_seq));

  // R7
  commit_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
    can_commit |-> hd_vld);
endmodule

// File: rtl/mt_rob.sv
module mt_rob
  import rob_pkg::*;
#(
  parameter int NTHR  = 2,
  parameter int DEPTH = 8,
  parameter int SEQW  = 16,
  parameter int PCW   = 32,
  parameter int SQW   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NTHR-1:0]        thr_act,
  input  logic                   ins_en,
  input  logic [idw(NTHR)-1:0]   ins_tid,
  input  logic [SEQW-1:0]        ins_seq,
  input  logic [PCW-1:0]         ins_pc,
  input  logic                   done_en,
  input  logic [idw(NTHR)-1:0]   done_tid,
  input  logic [SEQW-1:0]        done_seq,
  input  logic                   ret_en,
  input  logic [idw(NTHR)-1:0]   ret_tid,
  input  logic                   sq_en,
  input  logic [idw(NTHR)-1:0]   sq_tid,
  input  logic [SEQW-1:0]        sq_seq,
  output logic                   can_commit,
  output logic                   hd_vld,
  output logic [idw(NTHR)-1:0]   hd_tid,
  output logic [SEQW-1:0]        hd_seq,
  output logic [PCW-1:0]         hd_pc,
  output logic                   hd_rdy,
  output logic                   hd_sqd,
  output logic                   tl_vld,
  output logic [idw(NTHR)-1:0]   tl_tid,
  output logic [SEQW-1:0]        tl_seq,
  output logic [NTHR-1:0]        sq_busy,
  output logic [NTHR-1:0]        thr_full
);
  localparam int TW = idw(NTHR);

  logic [NTHR-1:0]           ne, hrdy, hsqd;
  logic [NTHR-1:0][SEQW-1:0] hseq, tseq;
  logic [NTHR-1:0][PCW-1:0]  hpc;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    rob_thread_q #(
      .DEPTH(DEPTH), .SEQW(SEQW), .PCW(PCW), .SQW(SQW)
    ) u_q (
      .clk      (clk),
      .rst      (rst),
      .ins_en   (ins_en  && ins_tid  == TW'(t)),
      .ins_seq  (ins_seq),
      .ins_pc   (ins_pc),
      .done_en  (done_en && done_tid == TW'(t)),
      .done_seq (done_seq),
      .ret_en   (ret_en  && ret_tid  == TW'(t)),
      .sq_en    (sq_en   && sq_tid   == TW'(t)),
      .sq_seq   (sq_seq),
      .nonempty (ne[t]),
      .full     (thr_full[t]),
      .head_rdy (hrdy[t]),
      .head_sqd (hsqd[t]),
      .busy     (sq_busy[t]),
      .head_seq (hseq[t]),
      .tail_seq (tseq[t]),
      .head_pc  (hpc[t])
    );
  end

  rob_pick #(.NTHR(NTHR), .SEQW(SEQW), .PCW(PCW)) u_pick (
    .clk        (clk),
    .rst        (rst),
    .act        (thr_act),
    .ne         (ne),
    .hrdy       (hrdy),
    .hsqd       (hsqd),
    .hseq       (hseq),
    .tseq       (tseq),
    .hpc        (hpc),
    .can_commit (can_commit),
    .hd_vld     (hd_vld),
    .hd_tid     (hd_tid),
    .hd_seq     (hd_seq),
    .hd_pc      (hd_pc),
    .hd_rdy     (hd_rdy),
    .hd_sqd     (hd_sqd),
    .tl_vld     (tl_vld),
    .tl_tid     (tl_tid),
    .tl_seq     (tl_seq)
  );

  // R8
  one_walker_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (ne == '0) |-> (sq_busy == '0));
endmodule

// File: tb/sim_mt_rob.sv
`timescale 1ns/1ps
module sim_mt_rob;
  localparam int NTHR = 2, DEPTH = 8, SEQW = 16, PCW = 32, SQW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NTHR-1:0] thr_act = '1;
  logic ins_en = 0, done_en = 0, ret_en = 0, sq_en = 0;
  logic ins_tid = 0, done_tid = 0, ret_tid = 0, sq_tid = 0;
  logic [SEQW-1:0] ins_seq = 0, done_seq = 0, sq_seq = 0;
  logic [PCW-1:0] ins_pc = 0;
  logic can_commit, hd_vld, hd_rdy, hd_sqd, tl_vld, hd_tid, tl_tid;
  logic [SEQW-1:0] hd_seq, tl_seq;
  logic [PCW-1:0] hd_pc;
  logic [NTHR-1:0] sq_busy, thr_full;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mt_rob #(.NTHR(NTHR), .DEPTH(DEPTH), .SEQW(SEQW), .PCW(PCW), .SQW(SQW)) u0 (
    .clk(clk), .rst(rst), .thr_act(thr_act),
    .ins_en(ins_en), .ins_tid(ins_tid), .ins_seq(ins_seq), .ins_pc(ins_pc),
    .done_en(done_en), .done_tid(done_tid), .done_seq(done_seq),
    .ret_en(ret_en), .ret_tid(ret_tid),
    .sq_en(sq_en), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .can_commit(can_commit), .hd_vld(hd_vld), .hd_tid(hd_tid), .hd_seq(hd_seq),
    .hd_pc(hd_pc), .hd_rdy(hd_rdy), .hd_sqd(hd_sqd),
    .tl_vld(tl_vld), .tl_tid(tl_tid), .tl_seq(tl_seq),
    .sq_busy(sq_busy), .thr_full(thr_full)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; thr_act = '1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic ins(input logic t, input int s, input int pc);
    ins_en = 1; ins_tid = t; ins_seq = SEQW'(s); ins_pc = PCW'(pc);
    @(negedge clk);
    ins_en = 0;
  endtask

  task automatic done(input logic t, input int s);
    done_en = 1; done_tid = t; done_seq = SEQW'(s);
    @(negedge clk);
    done_en = 0;
  endtask

  task automatic ret(input logic t);
    ret_en = 1; ret_tid = t;
    @(negedge clk);
    ret_en = 0;
  endtask

  task automatic sq(input logic t, input int s);
    sq_en = 1; sq_tid = t; sq_seq = SEQW'(s);
    @(negedge clk);
    sq_en = 0;
  endtask

  // samples for which sq_busy[t] stays high, starting right after the request
  task automatic busy_len(input int t, output int n);
    n = 0;
    while (sq_busy[t] && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    settle();
    chk("R1 hd_vld", hd_vld, 0);
    chk("R1 tl_vld", tl_vld, 0);
    chk("R1 can_commit", can_commit, 0);
    chk("R1 sq_busy", sq_busy, 0);
    chk("R1 thr_full", thr_full, 0);
  endtask

  task automatic t_order();
    do_reset();
    ins(0, 10, 'h100); ins(1, 11, 'h104); ins(0, 12, 'h108); ins(1, 13, 'h10c);
    settle();
    chk("R5 head seq", hd_seq, 10);
    chk("R5 head tid", hd_tid, 0);
    chk("R5 head pc", hd_pc, 'h100);
    chk("R6 tail seq", tl_seq, 13);
    chk("R6 tail tid", tl_tid, 1);
    chk("R7 idle commit", can_commit, 0);
    done(1, 11); settle();
    chk("R3 R7 other-thread ready", can_commit, 1);
    chk("R5 head not ready", hd_rdy, 0);
    ret(0); settle();
    chk("R4 unready retire ignored", hd_seq, 10);
    ret(1); settle();
    chk("R4 head kept", hd_seq, 10);
    chk("R7 commit dropped", can_commit, 0);
    chk("R6 tail kept", tl_seq, 13);
    done(0, 10); ret(0); settle();
    chk("R4 R2 next in order", hd_seq, 12);
    chk("R5 next pc", hd_pc, 'h108);
    thr_act = 2'b01; settle(); settle();
    chk("R5 mask head", hd_seq, 12);
    chk("R6 mask tail", tl_seq, 12);
    thr_act = 2'b10; settle(); settle();
    chk("R5 mask head t1", hd_tid, 1);
    chk("R5 mask seq t1", hd_seq, 13);
    thr_act = 2'b00; settle(); settle();
    chk("R5 none active", hd_vld, 0);
    thr_act = 2'b11;
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) ins(1, 50 + i, 'h200 + 4 * i);
    chk("R2 full t1", thr_full[1], 1);
    chk("R2 not full t0", thr_full[0], 0);
    settle();
    chk("R2 head", hd_seq, 50);
    chk("R6 tail", tl_seq, 50 + DEPTH - 1);
  endtask

  task automatic t_sq_mid();
    int n;
    do_reset();
    for (int i = 0; i < 5; i++) ins(0, 10 + i, 'h300 + 4 * i);
    ins(1, 15, 'h400);
    sq(0, 10);
    chk("R8 busy raised", sq_busy[0], 1);
    busy_len(0, n);
    // 14,13 then 12,11 then stop on 10
    chk("R9 R10 walk length", n, 3);
    settle();
    chk("R10 oldest untouched", hd_sqd, 0);
    chk("R10 oldest not ready", hd_rdy, 0);
    chk("R6 tail after squash", tl_seq, 15);
    done(0, 10); ret(0); settle();
    chk("R11 squashed head seq", hd_seq, 11);
    chk("R9 R11 squashed flag", hd_sqd, 1);
    chk("R9 squashed ready", hd_rdy, 1);
    chk("R11 drains", can_commit, 1);
  endtask

  task automatic t_sq_all();
    int n;
    do_reset();
    ins(0, 20, 'h500); ins(0, 21, 'h504); ins(0, 22, 'h508);
    sq(0, 5);
    busy_len(0, n);
    chk("R10 reach oldest", n, 2);
    settle();
    chk("R9 oldest squashed", hd_sqd, 1);
    chk("R11 can commit", can_commit, 1);
    ret(0); ret(0); ret(0); settle();
    chk("R11 all drained", hd_vld, 0);
  endtask

  task automatic t_sq_none();
    int n;
    do_reset();
    ins(0, 30, 'h600); ins(0, 31, 'h604);
    sq(0, 31);
    busy_len(0, n);
    chk("R10 immediate stop", n, 1);
    settle();
    chk("R9 nothing marked", can_commit, 0);
  endtask

  task automatic t_sq_empty();
    do_reset();
    sq(0, 0);
    chk("R8 empty buffer", sq_busy, 0);
    settle();
    chk("R8 empty head", hd_vld, 0);
    ins(1, 40, 'h700);
    sq(0, 0);
    chk("R8 empty thread", sq_busy, 0);
    settle();
    chk("R8 other thread intact", hd_sqd, 0);
    chk("R8 other seq", hd_seq, 40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_full();
    t_sq_mid();
    t_sq_all();
    t_sq_none();
    t_sq_empty();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule